// File: doc/BRIEF.md
# Double-Buffered PWM Duty Register

This block produces a pulse-width output from an 8-bit free-running up counter and a compare (duty) value. Each time the counter equals the compare value, the output flips. While the counter is stopped it is held at zero and the output sits low. When the counter is started again, the output begins low.

The duty value is reached through a small register interface: a write strobe with data, and a read strobe that loads the read data port. A mode input places a shadow buffer in front of the active compare value. With the shadow on and the counter running, writes land only in the shadow. The shadow moves into the active value on every second counter wrap, and a one-clock interrupt pulse marks that move. With the shadow off, a write takes effect in the cycle it is made. So a value equal to the counter matches at once, and a value below the counter waits for the next lap. Reads return the shadow contents when the shadow is on, and the active value when it is off.

Top module: `pwm_dbuf_top`

## Requirements
- R1: After reset, cnt_o is 0, pwm_o is 0, irq_o is 0 and rdata_o is 0.
- R2: While run_i is 0, cnt_o is 0 and pwm_o is 0 from the next cycle on. A write while stopped sets the active compare value and the shadow value at once, whatever the mode. After run_i rises, counting starts from 0 with pwm_o low.
- R3: While run_i is 1, cnt_o rises by one each clock and wraps from 255 to 0. Each wrap counts as one overflow, and the first overflow after a start is odd. pwm_o flips at the clock edge that ends a cycle in which cnt_o equals the effective compare value.
- R4: With dbuf_en_i=1 and the counter running, a write changes only the shadow. Compare matches keep using the previous active value until the transfer.
- R5: With dbuf_en_i=1, the shadow value becomes the active value at the end of every even overflow cycle (cnt_o=255 with an odd number of earlier overflows). irq_o is 1 for exactly the one cycle that follows, in which cnt_o is 0. There is no pulse on odd overflows.
- R6: When a shadow write and an even overflow fall in the same cycle, the written value is the one transferred.
- R7: With dbuf_en_i=0 and the counter running, a write is used for matching in the cycle it is made. Writing the current cnt_o value flips pwm_o at that same edge.
- R8: With dbuf_en_i=0, a written value below the current cnt_o causes no flip until the counter has wrapped and reaches the new value.
- R9: With dbuf_en_i=0, irq_o stays 0, and a read returns the active compare value.
- R10: rdata_o loads at the edge after a cycle with rd_i=1. It returns the shadow when dbuf_en_i=1 and the active value otherwise, both taken before any write in that cycle. rdata_o holds its value in cycles without rd_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | 1 = counter runs, 0 = counter held at zero |
| dbuf_en_i | input | 1 | 1 = shadow buffer in front of compare value |
| wr_i | input | 1 | Duty write strobe |
| wdata_i | input | 8 | Duty write data |
| rd_i | input | 1 | Duty read strobe |
| rdata_o | output | 8 | Duty read data, registered |
| cnt_o | output | 8 | Current counter value |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | One-cycle pulse on shadow transfer |

## Verification
A wrong overflow parity moves the transfer and the irq_o pulse by a full 256-cycle lap. It therefore shows at the first wrap after a start, as a pulse on the wrong lap. A stale or early active value shows as a pwm_o flip at the wrong counter value within one lap of the write. A shadow that is not loaded shows at the next read. A cycle-level reference model in the bench predicts cnt_o, pwm_o, irq_o and rdata_o for every clock, so any such difference is reported in the cycle it first appears.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  typedef enum logic [1:0] {
    WR_NONE,
    WR_DIRECT,
    WR_SHADOW
  } wr_path_e;
endpackage

// File: rtl/pwm_cnt.sv
module pwm_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             ovf_even_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             odd_q;  // set after an odd number of wraps

  assign ovf_o      = run_i && (cnt_q == CNT_MAX);
  assign ovf_even_o = ovf_o && odd_q;
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      odd_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      odd_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (ovf_o) odd_q <= ~odd_q;
    end
  end
endmodule

// File: rtl/pwm_duty.sv
module pwm_duty
  import pwm_dbuf_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             dbuf_en_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             rd_i,
  input  logic             ovf_even_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] act_q, shd_q, rdata_q;
  logic             irq_q;
  wr_path_e         path;

  always_comb begin
    if (!wr_i)                       path = WR_NONE;
    else if (!run_i || !dbuf_en_i)   path = WR_DIRECT;
    else                             path = WR_SHADOW;
  end

  // unbuffered running write is compared in its own cycle
  assign cmp_o = (path == WR_DIRECT && run_i) ? wdata_i : act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      shd_q <= '0;
    end else begin
      unique case (path)
        WR_DIRECT: begin
          act_q <= wdata_i;
          shd_q <= wdata_i;
        end
        WR_SHADOW: begin
          shd_q <= wdata_i;
          if (ovf_even_i) act_q <= wdata_i;
        end
        default: begin
          if (ovf_even_i && dbuf_en_i) act_q <= shd_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (rd_i) rdata_q <= dbuf_en_i ? shd_q : act_q;
      irq_q <= ovf_even_i && dbuf_en_i;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/pwm_out.sv
module pwm_out #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             pwm_o
);
  logic pwm_q;
  logic match;

  assign match = run_i && (cnt_i == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pwm_q <= 1'b0;
    else if (!run_i) pwm_q <= 1'b0;
    else             pwm_q <= pwm_q ^ match;
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/pwm_dbuf_top.sv
module pwm_dbuf_top #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             dbuf_en_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             rd_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pwm_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp;
  logic             ovf;
  logic             ovf_even;

  pwm_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .cnt_o      (cnt),
    .ovf_o      (ovf),
    .ovf_even_o (ovf_even)
  );

  pwm_duty #(.CNT_W(CNT_W)) u_duty (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .dbuf_en_i  (dbuf_en_i),
    .wr_i       (wr_i),
    .wdata_i    (wdata_i),
    .rd_i       (rd_i),
    .ovf_even_i (ovf_even),
    .cmp_o      (cmp),
    .rdata_o    (rdata_o),
    .irq_o      (irq_o)
  );

  pwm_out #(.CNT_W(CNT_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .cnt_i  (cnt),
    .cmp_i  (cmp),
    .pwm_o  (pwm_o)
  );

  assign cnt_o = cnt;
endmodule

// File: rtl/pwm_dbuf_chk.sv
module pwm_dbuf_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             dbuf_en_i,
  input logic             rd_i,
  input logic [CNT_W-1:0] rdata_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic             pwm_o,
  input logic             irq_o
);
  // R2
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_o == '0) && !pwm_o);

  // R3
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));

  // R5
  irq_at_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cnt_o == '0);

  // R5
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R9
  no_irq_unbuf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbuf_en_i |=> !irq_o);

  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

bind pwm_dbuf_top pwm_dbuf_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_i     (run_i),
  .dbuf_en_i (dbuf_en_i),
  .rd_i      (rd_i),
  .rdata_o   (rdata_o),
  .cnt_o     (cnt_o),
  .pwm_o     (pwm_o),
  .irq_o     (irq_o)
);

// File: tb/tb_pwm_dbuf_top.sv
module tb_pwm_dbuf_top;
  localparam int  W          = 8;
  localparam time CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         run = 1'b0, dbuf = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [W-1:0] wd = '0;
  logic [W-1:0] rdata_o, cnt_o;
  logic         pwm_o, irq_o;

  int n_chk = 0;
  int n_err = 0;

  pwm_dbuf_top #(.CNT_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .dbuf_en_i(dbuf),
    .wr_i(wr), .wdata_i(wd), .rd_i(rd), .rdata_o(rdata_o),
    .cnt_o(cnt_o), .pwm_o(pwm_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model written from the requirements
  typedef struct packed {
    logic [W-1:0] cnt;
    logic         pwm;
    logic         irq;
    logic [W-1:0] rdata;
  } exp_t;

  exp_t         sb_q[$];
  logic [W-1:0] m_cnt, m_act, m_buf, m_rd, m_eff;
  logic         m_odd, m_pwm, m_irq, m_match, m_even;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '0; m_act = '0; m_buf = '0; m_rd = '0;
      m_odd = 1'b0; m_pwm = 1'b0; m_irq = 1'b0;
      sb_q.delete();
    end else begin
      m_eff   = (run && wr && !dbuf) ? wd : m_act;             // R7
      m_match = run && (m_cnt == m_eff);                       // R3
      m_even  = run && (m_cnt == 8'hFF) && m_odd;              // R5
      if (rd) m_rd = dbuf ? m_buf : m_act;                     // R10 R9
      if (wr && (!run || !dbuf)) begin                         // R2 R7
        m_act = wd; m_buf = wd;
      end else if (wr) begin                                   // R4 R6
        m_buf = wd;
        if (m_even) m_act = wd;
      end else if (m_even && dbuf) begin                       // R5
        m_act = m_buf;
      end
      m_irq = m_even && dbuf;
      m_pwm = run ? (m_pwm ^ m_match) : 1'b0;
      if (run) begin
        if (m_cnt == 8'hFF) m_odd = ~m_odd;
        m_cnt = m_cnt + 1'b1;
      end else begin
        m_cnt = '0; m_odd = 1'b0;
      end
      sb_q.push_back('{cnt: m_cnt, pwm: m_pwm, irq: m_irq, rdata: m_rd});
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(cnt_o == e.cnt, "R3 counter", cnt_o, e.cnt);
      check(pwm_o == e.pwm, "R3 R7 R8 pwm", pwm_o, e.pwm);
      check(irq_o == e.irq, "R5 irq", irq_o, e.irq);
      check(rdata_o == e.rdata, "R10 rdata", rdata_o, e.rdata);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_cnt(input logic [W-1:0] v);
    do @(negedge clk); while (cnt_o != v);
  endtask

  task automatic do_write(input logic [W-1:0] v);
    wr = 1'b1; wd = v;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_read();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic p;
    int   irqs;
    tick(3);
    // R1
    check(cnt_o == 0 && pwm_o == 0 && irq_o == 0 && rdata_o == 0, "R1 reset", cnt_o, 0);
    rst_n = 1'b1;
    tick(2);

    // R2: stopped write, buffered mode
    dbuf = 1'b1;
    do_write(8'd10);
    do_read();
    check(rdata_o == 10, "R2 stopped read", rdata_o, 10);
    tick(5);
    check(cnt_o == 0 && pwm_o == 0, "R2 held", cnt_o, 0);

    // lap 1 (ends odd overflow)
    run = 1'b1;
    wait_cnt(8'd20);
    do_write(8'd50);
    do_read();
    check(rdata_o == 50, "R4 read shadow", rdata_o, 50);
    wait_cnt(8'hFF);
    @(negedge clk);
    check(irq_o == 0, "R5 no irq on odd wrap", irq_o, 0);
    // lap 2: old value still active
    wait_cnt(8'd10);
    p = pwm_o;
    @(negedge clk);
    check(pwm_o == !p, "R4 old value matches", pwm_o, !p);
    wait_cnt(8'd50);
    p = pwm_o;
    @(negedge clk);
    check(pwm_o == p, "R4 new value not yet used", pwm_o, p);
    wait_cnt(8'hFF);
    @(negedge clk);
    check(irq_o == 1, "R5 irq on even wrap", irq_o, 1);
    @(negedge clk);
    check(irq_o == 0, "R5 irq one cycle", irq_o, 0);
    // lap 3: new value active
    wait_cnt(8'd50);
    p = pwm_o;
    @(negedge clk);
    check(pwm_o == !p, "R5 transferred value matches", pwm_o, !p);
    wait_cnt(8'hFF);
    // lap 4: write in the even overflow cycle
    wait_cnt(8'hFF);
    do_write(8'd77);
    check(irq_o == 1, "R6 irq", irq_o, 1);
    wait_cnt(8'd77);
    p = pwm_o;
    @(negedge clk);
    check(pwm_o == !p, "R6 same-cycle write transferred", pwm_o, !p);

    // unbuffered
    dbuf = 1'b0;
    wait_cnt(8'd100);
    p = pwm_o;
    do_write(8'd100);
    check(pwm_o == !p, "R7 equal write matches at once", pwm_o, !p);
    wait_cnt(8'd150);
    p = pwm_o;
    do_write(8'd30);
    begin
      bit steady = 1'b1;
      while (cnt_o != 0) begin
        if (pwm_o != p) steady = 1'b0;
        @(negedge clk);
      end
      check(steady, "R8 no flip before wrap", pwm_o, p);
    end
    wait_cnt(8'd30);
    @(negedge clk);
    check(pwm_o == !p, "R8 flip after wrap", pwm_o, !p);
    do_read();
    check(rdata_o == 30, "R9 read active", rdata_o, 30);
    irqs = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (irq_o) irqs++;
    end
    check(irqs == 0, "R9 no irq unbuffered", irqs, 0);
    do_write(8'd40);
    tick(3);
    check(rdata_o == 30, "R10 hold without read", rdata_o, 30);

    // R2: stop, write, restart
    run = 1'b0;
    tick(2);
    check(cnt_o == 0 && pwm_o == 0, "R2 stop clears", cnt_o, 0);
    dbuf = 1'b1;
    do_write(8'd200);
    do_read();
    check(rdata_o == 200, "R2 stopped write to shadow", rdata_o, 200);
    run = 1'b1;
    @(negedge clk);
    check(pwm_o == 0, "R2 restart low", pwm_o, 0);
    wait_cnt(8'd200);
    @(negedge clk);
    check(pwm_o == 1, "R2 stopped write active", pwm_o, 1);
    tick(600);
    tick(2);
    finish_run();
  end
endmodule